// File: doc/BRIEF.md
# Output Impedance Calibration Stepper

This block steers the 5-bit strength code of an output driver toward the value that matches the board's line impedance. An external comparator, modelled here as two level inputs, reports whether the present code sits below or above the optimum. A free-running evaluation counter fires once every `EVAL_PERIOD` clocks. On each firing the working code moves by at most one step toward the target. It holds when the comparator reports neither direction.

The working code is not applied to the driver straight away. The driver code is loaded only on the clock edge where the output enters high impedance. That entry is requested by a write cycle, a deselect cycle, or the output enable being dropped. Loading at that edge means the strength never changes while data is being driven.

A settle counter starts at reset and saturates after `SETTLE_CYCLES` clocks. A sticky `cal_settled` flag reports the first driver load that happens after the counter has saturated.

Top module: `impcal_stepper`

## Requirements
- R1: The working code can change only on an evaluation edge. The first evaluation edge is the 64th rising clock edge after reset release, and each later one follows 64 edges after the previous one.
- R2: On an evaluation edge, `cmp_low`=1 with `cmp_high`=0 raises the working code by one. `cmp_high`=1 with `cmp_low`=0 lowers it by one. Both inputs low, or both high, leave it unchanged.
- R3: The working code saturates at 31 and at 0 and never wraps.
- R4: While reset is asserted, `work_code` and `drv_code` are 16, `drv_hiz` is 1 and `cal_settled` is 0.
- R5: `drv_hiz` equals, one edge later, the high-impedance request (`bus_write` OR `bus_desel` OR NOT `out_en`) sampled at that edge.
- R6: `drv_code` loads the working code held before the edge, and does so only on an edge where the high-impedance request is 1 while `drv_hiz` is 0. On every other edge it holds.
- R7: `cal_settled` becomes 1 on the first load edge (as defined in R6) that occurs once at least 4096 edges have passed since reset release. It then stays 1 until reset.
- R8: Load edges that occur before 4096 edges have passed leave `cal_settled` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_low | input | 1 | Comparator: code is below optimum |
| cmp_high | input | 1 | Comparator: code is above optimum |
| bus_write | input | 1 | Current bus cycle is a write |
| bus_desel | input | 1 | Current bus cycle is a deselect |
| out_en | input | 1 | Output enable, sampled synchronously; 0 requests high impedance |
| work_code | output | 5 | Working impedance code |
| drv_code | output | 5 | Code applied to the driver |
| drv_hiz | output | 1 | Driver is in high impedance |
| cal_settled | output | 1 | Calibration is settled (sticky) |

## Verification
The assertions assume all inputs are synchronous to `clk` and stable around its rising edge. They also assume the comparator may report both directions at once, which the block treats as a hold. The stimulus drives every input at the falling edge. It lets the comparator inputs take all four combinations, including long runs in one direction that press the code against both rails. The bus-cycle and enable inputs are random and independent, so load edges occur both before and after the settle point.

// File: rtl/impcal_stepper.sv
module impcal_stepper #(
  parameter int unsigned CODE_W        = 5,
  parameter int unsigned EVAL_PERIOD   = 64,
  parameter int unsigned SETTLE_CYCLES = 4096,
  parameter int unsigned RESET_CODE    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_low,
  input  logic              cmp_high,
  input  logic              bus_write,
  input  logic              bus_desel,
  input  logic              out_en,
  output logic [CODE_W-1:0] work_code,
  output logic [CODE_W-1:0] drv_code,
  output logic              drv_hiz,
  output logic              cal_settled
);

  localparam int unsigned EVAL_W = (EVAL_PERIOD > 1) ? $clog2(EVAL_PERIOD) : 1;
  localparam int unsigned SET_W  = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(RESET_CODE);

  logic [EVAL_W-1:0] eval_cnt;
  logic [SET_W-1:0]  settle_cnt;
  logic eval_tick, step_up, step_dn, hiz_req, hiz_enter, expired;

  assign eval_tick = (eval_cnt == EVAL_W'(EVAL_PERIOD - 1));
  assign step_up   = eval_tick & cmp_low & ~cmp_high & (work_code != CODE_MAX);
  assign step_dn   = eval_tick & cmp_high & ~cmp_low & (work_code != '0);
  assign hiz_req   = bus_write | bus_desel | ~out_en;
  assign hiz_enter = hiz_req & ~drv_hiz;
  assign expired   = (settle_cnt == SET_W'(SETTLE_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eval_cnt    <= '0;
      settle_cnt  <= '0;
      work_code   <= CODE_RST;
      drv_code    <= CODE_RST;
      drv_hiz     <= 1'b1;
      cal_settled <= 1'b0;
    end else begin
      eval_cnt <= eval_tick ? '0 : eval_cnt + 1'b1;
      if (!expired) settle_cnt <= settle_cnt + 1'b1;
      if (step_up) work_code <= work_code + 1'b1;
      else if (step_dn) work_code <= work_code - 1'b1;
      drv_hiz <= hiz_req;
      if (hiz_enter) drv_code <= work_code;
      if (hiz_enter && expired) cal_settled <= 1'b1;
    end
  end

  a_r1_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_tick |=> $stable(work_code));

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(work_code) |-> (work_code == $past(work_code) + 1'b1) || (work_code == $past(work_code) - 1'b1));

  a_r3_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    (work_code == CODE_MAX) |=> (work_code != '0));

  a_r3_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (work_code == '0) |=> (work_code != CODE_MAX));

  a_r5_hiz_follows: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_req |=> drv_hiz);

  a_r6_load_only_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    !hiz_enter |=> $stable(drv_code));

  a_r7_settled_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cal_settled |=> cal_settled);

  a_r8_no_early_settle: assert property (@(posedge clk) disable iff (!rst_n)
    !expired |=> !$rose(cal_settled));

endmodule

// File: tb/impcal_stepper_bench.sv
`timescale 1ns/1ps
module impcal_stepper_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_low = 1'b0, cmp_high = 1'b0, bus_write = 1'b0, bus_desel = 1'b0, out_en = 1'b1;
  logic [4:0] work_code, drv_code;
  logic drv_hiz, cal_settled;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_work, m_drv, m_hiz, m_set, m_tick, m_cyc;

  always #4 clk = ~clk;

  impcal_stepper u_impcal_stepper (
    .clk(clk), .rst_n(rst_n), .cmp_low(cmp_low), .cmp_high(cmp_high),
    .bus_write(bus_write), .bus_desel(bus_desel), .out_en(out_en),
    .work_code(work_code), .drv_code(drv_code), .drv_hiz(drv_hiz),
    .cal_settled(cal_settled)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_work = 16; m_drv = 16; m_hiz = 1; m_set = 0; m_tick = 0; m_cyc = 0;
    end else begin
      int req, old_work;
      bit ripe;
      req = (bus_write || bus_desel || !out_en) ? 1 : 0;
      ripe = (m_cyc >= 4096);
      old_work = m_work;
      m_tick = m_tick + 1;
      if (m_tick == 64) begin
        m_tick = 0;
        if (cmp_low && !cmp_high && m_work < 31) m_work = m_work + 1;
        else if (cmp_high && !cmp_low && m_work > 0) m_work = m_work - 1;
      end
      if (req == 1 && m_hiz == 0) begin
        m_drv = old_work;
        if (ripe) m_set = 1;
      end
      m_hiz = req;
      m_cyc = m_cyc + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(work_code == m_work, "R1 R2 R3 work_code", work_code, m_work);
    chk(drv_code == m_drv, "R6 drv_code", drv_code, m_drv);
    chk(drv_hiz == m_hiz[0], "R5 drv_hiz", drv_hiz, m_hiz);
    chk(cal_settled == m_set[0], "R7 R8 cal_settled", cal_settled, m_set);
  endtask

  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      case (mode)
        0: begin cmp_low = 1; cmp_high = 0; end
        1: begin cmp_low = 0; cmp_high = 1; end
        2: begin cmp_low = 0; cmp_high = 0; end
        3: begin cmp_low = 1; cmp_high = 1; end
        default: begin cmp_low = $urandom_range(0, 1); cmp_high = $urandom_range(0, 1); end
      endcase
      bus_write = ($urandom_range(0, 7) == 0);
      bus_desel = ($urandom_range(0, 7) == 0);
      out_en    = ($urandom_range(0, 5) != 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(work_code == 5'd16, "R4 work_code reset", work_code, 16);
    chk(drv_code == 5'd16, "R4 drv_code reset", drv_code, 16);
    chk(drv_hiz == 1'b1, "R4 drv_hiz reset", drv_hiz, 1);
    chk(cal_settled == 1'b0, "R4 cal_settled reset", cal_settled, 0);
    rst_n = 1'b1;
    run(1000, 0);
    chk(work_code == 5'd31, "R3 saturate high", work_code, 31);
    run(2100, 1);
    chk(work_code == 5'd0, "R3 saturate low", work_code, 0);
    chk(cal_settled == 1'b0, "R8 early loads ignored", cal_settled, 0);
    run(300, 3);
    chk(work_code == 5'd0, "R2 both asserted holds", work_code, 0);
    run(300, 2);
    chk(work_code == 5'd0, "R2 neither asserted holds", work_code, 0);
    run(1000, 4);
    chk(cal_settled == 1'b1, "R7 settled after 4096", cal_settled, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule